// File: doc/BRIEF.md
# Nested Integer Square-Root Pipeline

This block evaluates floor(sqrt(A + floor(sqrt(B + floor(sqrt(C)))))) on three unsigned operands. It is fully pipelined. It takes one operand triple per clock through a valid/ready handshake on its input side. Results leave through a second valid/ready handshake on its output side.

Inside, three fixed-latency square-root units are chained. Each unit resolves its root with the restoring bit-by-bit method, spread evenly over N register stages. The B operand travels through a delay line of N stages, so it meets the first root at the first adder. One register sits after that adder. The A operand travels through a delay line of 2*N+1 stages, so it meets the second root at the second adder. Every stage carries a valid bit alongside its data.

Back-pressure is global: when the consumer refuses a valid result, every register in the datapath holds. This includes the root units, the delay lines and the middle register. The same advance signal drives the input ready, so a bubble at the output never blocks intake.

Top module: `nested_sqrt_pipe`

## Requirements
- R1: For every accepted triple (A, B, C), with each operand 16 bits, the result equals floor(sqrt(A + floor(sqrt(B + floor(sqrt(C)))))). The result is an unsigned 9-bit value, and every intermediate sum is 17 bits wide.
- R2: With the consumer always ready, a triple accepted at a clock edge appears on the output exactly 3*N+1 edges later, which is 13 for N = 4.
- R3: Triples presented on consecutive cycles with the consumer ready produce results on consecutive cycles, one per clock, with no gaps.
- R4: in_rdy is high exactly when out_vld is low or out_rdy is high.
- R5: While out_vld is high and out_rdy is low, no register in the pipeline changes. On the next cycle out_vld stays high and out_root keeps its value.
- R6: Every accepted triple yields exactly one result, in acceptance order, whatever the pattern of stalls and idle cycles.
- R7: Reset (active-low, asynchronous) clears every valid bit. out_vld stays low and in_rdy stays high until an accepted triple reaches the output.
- R8: The valid bit of the B delay line always equals the output-valid flag of the first root unit. The valid bit of the A delay line always equals the output-valid flag of the second root unit.
- R9: A cycle in which no triple is accepted produces no result: out_vld is never high unless an accepted triple is still owed.
- R10: Extreme operands are handled without overflow: all-zero operands give 0, and all operands at 16'hFFFF give 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand triple on in_a/in_b/in_c is valid |
| in_rdy | output | 1 | Pipeline advances this cycle and will take a triple |
| in_a | input | W (16) | Outer operand A |
| in_b | input | W (16) | Middle operand B |
| in_c | input | W (16) | Innermost operand C |
| out_vld | output | 1 | out_root holds a result |
| out_rdy | input | 1 | Consumer takes the result this cycle |
| out_root | output | (W+2)/2 (9) | Final floor square root |

## Verification
A result is due 3*N+1 clock edges after the edge that accepts its triple, and each stalled cycle pushes it back by exactly one edge. The bench drives inputs and samples outputs one time unit after the falling edge. It records each expected result in a queue at the cycle of acceptance and pops that queue only in a cycle where out_vld and out_rdy are both high, so results are checked in order whatever the stall pattern. A dedicated single-item test counts cycles from acceptance to the first out_vld and expects exactly 13. A streaming test expects an unbroken run of 40 results.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

   // Width of floor(sqrt(x)) for an x of rad_w bits.
   function automatic int root_w(input int rad_w);
      return (rad_w + 1) / 2;
   endfunction

   // Result bits each stage resolves when res_w bits are spread over stages.
   function automatic int bits_per_stage(input int res_w, input int stages);
      return (res_w + stages - 1) / stages;
   endfunction

endpackage

// File: rtl/nsq_sqrt_pipe.sv
module nsq_sqrt_pipe
   import nsq_pkg::*;
#(
   parameter int RAD_W = 16,
   parameter int STAGES = 4,
   localparam int RES_W = (RAD_W + 1) / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             in_vld,
   input  logic [RAD_W-1:0] in_rad,
   output logic             out_vld,
   output logic [RES_W-1:0] out_root
);

   localparam int BPS  = bits_per_stage(root_w(RAD_W), STAGES);
   localparam int SQ_W = RAD_W + 2;

   if (STAGES < 1) begin : g_bad_stages
      $error("nsq_sqrt_pipe: STAGES must be at least 1");
   end
   if (RAD_W < 2) begin : g_bad_width
      $error("nsq_sqrt_pipe: RAD_W must be at least 2");
   end

   // Inputs of each stage.
   logic [RAD_W-1:0] x_i  [STAGES];
   logic [RES_W-1:0] q_i  [STAGES];
   logic [SQ_W-1:0]  sq_i [STAGES];
   logic             v_i  [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [RES_W-1:0] q_nx;
      logic [SQ_W-1:0]  sq_nx;
      logic [RES_W-1:0] q_q;
      logic             v_q;

      if (g == 0) begin : g_head
         assign x_i[g]  = in_rad;
         assign q_i[g]  = '0;
         assign sq_i[g] = '0;
         assign v_i[g]  = in_vld;
      end else begin : g_link
         assign x_i[g]  = g_st[g-1].g_carry.x_q;
         assign q_i[g]  = g_st[g-1].q_q;
         assign sq_i[g] = g_st[g-1].g_carry.sq_q;
         assign v_i[g]  = g_st[g-1].v_q;
      end

      // Restoring trial per bit: (q + 2^b)^2 = q^2 + q*2^(b+1) + 2^(2b).
      always_comb begin
         int               bi;
         logic [SQ_W-1:0]  trial;
         q_nx  = q_i[g];
         sq_nx = sq_i[g];
         trial = '0;
         for (int k = 0; k < BPS; k++) begin
            bi = RES_W - 1 - (g * BPS + k);
            if (bi >= 0) begin
               trial = sq_nx + (SQ_W'(q_nx) << (bi + 1)) + (SQ_W'(1) << (2 * bi));
               if (trial <= SQ_W'(x_i[g])) begin
                  q_nx[bi] = 1'b1;
                  sq_nx    = trial;
               end
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   v_q <= 1'b0;
         else if (adv) v_q <= v_i[g];
      end

      always_ff @(posedge clk) begin
         if (adv) q_q <= q_nx;
      end

      if (g < STAGES - 1) begin : g_carry
         logic [RAD_W-1:0] x_q;
         logic [SQ_W-1:0]  sq_q;
         always_ff @(posedge clk) begin
            if (adv) begin
               x_q  <= x_i[g];
               sq_q <= sq_nx;
            end
         end
      end
   end

   assign out_vld  = g_st[STAGES-1].v_q;
   assign out_root = g_st[STAGES-1].q_q;

endmodule

// File: rtl/nsq_delay.sv
module nsq_delay #(
   parameter int W = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         in_vld,
   input  logic [W-1:0] in_data,
   output logic         out_vld,
   output logic [W-1:0] out_data
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("nsq_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign out_vld  = in_vld;
      assign out_data = in_data;
   end else begin : g_shift
      logic [W-1:0] d_r [DEPTH];
      logic         v_r [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) v_r[i] <= 1'b0;
         end else if (adv) begin
            v_r[0] <= in_vld;
            for (int i = 1; i < DEPTH; i++) v_r[i] <= v_r[i-1];
         end
      end

      always_ff @(posedge clk) begin
         if (adv) begin
            d_r[0] <= in_data;
            for (int i = 1; i < DEPTH; i++) d_r[i] <= d_r[i-1];
         end
      end

      assign out_vld  = v_r[DEPTH-1];
      assign out_data = d_r[DEPTH-1];
   end

endmodule

// File: rtl/nested_sqrt_pipe.sv
module nested_sqrt_pipe
   import nsq_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 4,
   localparam int OW = (W + 2) / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   output logic          in_rdy,
   input  logic [W-1:0]  in_a,
   input  logic [W-1:0]  in_b,
   input  logic [W-1:0]  in_c,
   output logic          out_vld,
   input  logic          out_rdy,
   output logic [OW-1:0] out_root
);

   localparam int R1W = root_w(W);
   localparam int S1W = W + 1;
   localparam int R2W = root_w(S1W);
   localparam int S2W = W + 1;
   localparam int A_DEPTH = 2 * N + 1;

   if (W < 4) begin : g_bad_w
      $error("nested_sqrt_pipe: W must be at least 4");
   end
   if (N < 1 || N > R1W) begin : g_bad_n
      $error("nested_sqrt_pipe: N must lie between 1 and the root width of C");
   end
   if (root_w(S2W) != OW) begin : g_bad_ow
      $error("nested_sqrt_pipe: output width mismatch");
   end

   // Global advance: every register moves together or not at all.
   logic adv;
   assign adv    = !out_vld || out_rdy;
   assign in_rdy = adv;

   // Stage 1: sqrt(C) alongside B delayed by N.
   logic           v1, vb;
   logic [R1W-1:0] r1;
   logic [W-1:0]   b_d;

   nsq_sqrt_pipe #(.RAD_W(W), .STAGES(N)) u_root_c (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(in_vld), .in_rad(in_c),
      .out_vld(v1), .out_root(r1)
   );

   nsq_delay #(.W(W), .DEPTH(N)) u_dly_b (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(in_vld), .in_data(in_b),
      .out_vld(vb), .out_data(b_d)
   );

   // Register stage between the first and second root units.
   logic [S1W-1:0] sum1, s1_q;
   logic           s1_v;
   assign sum1 = {1'b0, b_d} + S1W'(r1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   s1_v <= 1'b0;
      else if (adv) s1_v <= v1 && vb;
   end

   always_ff @(posedge clk) begin
      if (adv) s1_q <= sum1;
   end

   // Stage 2: sqrt(B + sqrt(C)) alongside A delayed by 2N+1.
   logic           v2, va;
   logic [R2W-1:0] r2;
   logic [W-1:0]   a_d;

   nsq_sqrt_pipe #(.RAD_W(S1W), .STAGES(N)) u_root_mid (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(s1_v), .in_rad(s1_q),
      .out_vld(v2), .out_root(r2)
   );

   nsq_delay #(.W(W), .DEPTH(A_DEPTH)) u_dly_a (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(in_vld), .in_data(in_a),
      .out_vld(va), .out_data(a_d)
   );

   // Stage 3: outer root, feeding the output directly.
   logic [S2W-1:0] sum2;
   assign sum2 = {1'b0, a_d} + S2W'(r2);

   nsq_sqrt_pipe #(.RAD_W(S2W), .STAGES(N)) u_root_out (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(v2 && va), .in_rad(sum2),
      .out_vld(out_vld), .out_root(out_root)
   );

endmodule

// File: rtl/nested_sqrt_pipe_checker.sv
module nested_sqrt_pipe_checker #(
   parameter int OW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_vld,
   input logic          out_rdy,
   input logic [OW-1:0] out_root,
   input logic          adv,
   input logic          v1,
   input logic          vb,
   input logic          v2,
   input logic          va,
   input logic          s1_v
);

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |-> (!out_vld && !s1_v && !vb && !va));

   assert_output_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_rdy) |=> (out_vld && $stable(out_root)));

   assert_global_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(s1_v) && $stable(vb) && $stable(va) && $stable(v2)));

   assert_b_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vb == v1);

   assert_a_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      va == v2);

endmodule

bind nested_sqrt_pipe nested_sqrt_pipe_checker #(.OW(OW)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_vld(out_vld), .out_rdy(out_rdy),
   .out_root(out_root), .adv(adv), .v1(v1), .vb(vb), .v2(v2), .va(va),
   .s1_v(s1_v)
);

// File: tb/nested_sqrt_pipe_bench.sv
module nested_sqrt_pipe_bench;

   localparam int PERIOD = 10;
   localparam int W      = 16;
   localparam int N      = 4;
   localparam int OW     = (W + 2) / 2;
   localparam int LAT    = 3 * N + 1;
   localparam int NV     = 8;

   // {A, B, C, expected}
   localparam logic [63:0] VEC [NV] = '{
      {16'd0,     16'd0,     16'd0,     16'd0},
      {16'd65535, 16'd65535, 16'd65535, 16'd256},
      {16'd0,     16'd0,     16'd1,     16'd1},
      {16'd100,   16'd20,    16'd16,    16'd10},
      {16'd3,     16'd5,     16'd4,     16'd2},
      {16'd1000,  16'd500,   16'd10000, 16'd32},
      {16'd65535, 16'd0,     16'd0,     16'd255},
      {16'd0,     16'd65535, 16'd0,     16'd15}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic          out_rdy = 1'b0;
   logic [W-1:0]  in_a = '0, in_b = '0, in_c = '0;
   logic          in_rdy, out_vld;
   logic [OW-1:0] out_root;

   always #(PERIOD / 2) clk = ~clk;

   nested_sqrt_pipe #(.W(W), .N(N)) u_nested_sqrt_pipe (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
      .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_root(out_root)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0, head = 0, tail = 0, n_pop = 0, run = 0, max_run = 0;
   int exp_q [512];
   bit hold_pend = 0;
   logic [OW-1:0] hold_val = '0;
   bit seen = 0;
   int seen_cyc = 0;
   bit done = 0;

   function automatic int isq(input int x);
      int r = 0;
      while ((r + 1) * (r + 1) <= x) r++;
      return r;
   endfunction

   function automatic int model(input int a, input int b, input int c);
      return isq(a + isq(b + isq(c)));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // One clock: drive at the falling edge, sample 1 unit later, then wait for the rising edge.
   task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic rdy, input int expv,
                       output bit acc);
      @(negedge clk);
      in_vld = v; in_a = a; in_b = b; in_c = c; out_rdy = rdy;
      #1;
      if (hold_pend) begin
         chk(out_vld === 1'b1, "R5 valid held", int'(out_vld), 1);
         chk(out_root === hold_val, "R5 value held", int'(out_root), int'(hold_val));
      end
      hold_pend = out_vld && !out_rdy;
      hold_val  = out_root;
      chk(in_rdy === (!out_vld || out_rdy), "R4 ready rule", int'(in_rdy),
          int'(!out_vld || out_rdy));
      if (out_vld && !seen) begin
         seen = 1; seen_cyc = cyc;
      end
      if (out_vld && head == tail) begin
         chk(1'b0, "R9 result with nothing owed", int'(out_root), -1);
      end else if (out_vld && out_rdy) begin
         chk(int'(out_root) == exp_q[head], "R1/R6 result", int'(out_root), exp_q[head]);
         head++; n_pop++;
      end
      if (out_vld && out_rdy) begin
         run++;
         if (run > max_run) max_run = run;
      end else begin
         run = 0;
      end
      acc = in_vld && in_rdy;
      if (acc) begin
         exp_q[tail] = expv;
         tail++;
      end
      @(posedge clk);
      cyc++;
   endtask

   task automatic idle(input int cycles);
      bit acc;
      for (int i = 0; i < cycles; i++) step(1'b0, '0, '0, '0, 1'b1, 0, acc);
   endtask

   initial begin
      bit acc;
      int it, start, pops0;
      logic [W-1:0] ga, gb, gc;

      // Reset state (R7)
      repeat (2) @(negedge clk);
      #1;
      chk(out_vld === 1'b0, "R7 out_vld in reset", int'(out_vld), 0);
      chk(in_rdy === 1'b1, "R7 in_rdy in reset", int'(in_rdy), 1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_vld === 1'b0, "R7 out_vld after reset", int'(out_vld), 0);
      idle(2);

      // Vector table: R1 and R10 (rows 0 and 1 are the extremes)
      for (int i = 0; i < NV; i++) begin
         chk(model(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:16]))
             == int'(VEC[i][15:0]), "R1 table self-consistency",
             model(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:16])),
             int'(VEC[i][15:0]));
         step(1'b1, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], 1'b1,
              int'(VEC[i][15:0]), acc);
         chk(acc, "R4 table item accepted", int'(acc), 1);
      end
      idle(LAT + 2);
      chk(head == tail, "R10 table drained", tail - head, 0);

      // Latency of a single item (R2)
      seen = 0;
      start = cyc;
      step(1'b1, 16'd400, 16'd9, 16'd81, 1'b1, model(400, 9, 81), acc);
      for (int i = 0; i < 3 * LAT && !seen; i++) idle(1);
      chk(seen && (seen_cyc - start) == LAT, "R2 latency", seen_cyc - start, LAT);
      idle(2);

      // Back-to-back stream (R3)
      pops0 = n_pop;
      max_run = 0;
      for (int i = 0; i < 40; i++) begin
         ga = 16'(i * 1733 + 5); gb = 16'(i * 977 + 11); gc = 16'(i * 4099 + 3);
         step(1'b1, ga, gb, gc, 1'b1, model(int'(ga), int'(gb), int'(gc)), acc);
      end
      idle(LAT);
      chk(n_pop - pops0 == 40, "R3 results in window", n_pop - pops0, 40);
      chk(max_run >= 40, "R3 unbroken output run", max_run, 40);

      // Stalls and bubbles mixed (R5, R6, R9)
      it = 0;
      for (int k = 0; k < 600 && (it < 30 || head != tail); k++) begin
         ga = 16'(it * 31337 + 7); gb = 16'(it * 2654 + 1); gc = 16'(it * 40503 + 9);
         step((k % 4 != 1) && it < 30, ga, gb, gc, (k % 3) != 0,
              model(int'(ga), int'(gb), int'(gc)), acc);
         if (acc) it++;
      end
      chk(it == 30, "R6 all items accepted", it, 30);
      chk(head == tail, "R6 no result lost", tail - head, 0);
      idle(LAT + 2);
      chk(out_vld === 1'b0, "R9 idle after drain", int'(out_vld), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule